// File: doc/BRIEF.md
# Dual-Core Message Mailbox

This block sits between a low-power core and a high-performance core and gives them a shared bank of sixteen 32-bit message slots plus a per-core interrupt path. Each core has its own simple register port, made up of select, write strobe, word address, write data and combinational read data. Either core may read or write any slot and any control register. A write to a slot notifies both cores: the slot's pending bit is raised in both interrupt banks, whichever port performed the write. Each core masks and acknowledges its own bank independently.

The word address space has two halves. When the top address bit is 0, the lower five bits select a slot. Only indices 0 to 15 exist. When the top address bit is 1, the lower bits select a control register:

| Offset | Register |
| --- | --- |
| 0x20 | gate, bit 0 |
| 0x21 | low-power pending |
| 0x22 | low-power mask |
| 0x23 | low-power status |
| 0x24 | low-power acknowledge |
| 0x25 | high-performance pending |
| 0x26 | high-performance mask |
| 0x27 | high-performance status |
| 0x28 | high-performance acknowledge |

Bit i of every bank register refers to slot i. Unused offsets read 0. Writes to the pending and status registers have no effect.

When both ports write the same storage in the same cycle, the high-performance port wins. Reset is asynchronous active-low, and the block releases it synchronously through a two-stage synchroniser.

Top module: `dual_core_mailbox`

## Requirements
- R1: After reset, every slot reads 0, all pending and mask bits are 0, the gate bit (0x20 bit 0) is 0, and both interrupt outputs are low.
- R2: While the gate bit is 0, slot and bank register writes have no effect and their reads return 0. The gate register itself is always readable and writable.
- R3: A write to slot address 0..15 from either port stores the 32-bit word, and both ports read it back.
- R4: Slot addresses 16..31 read as 0. Writes to them change no slot and raise no pending bit.
- R5: A write to slot i sets pending bit i in both the low-power bank (0x21) and the high-performance bank (0x25), whichever port wrote.
- R6: Writing a mask to a bank's acknowledge register (0x24 or 0x28) clears those pending bits in that bank only. Acknowledge registers read 0.
- R7: Mask registers (0x22, 0x26) are read and written as whole words. Clearing a mask bit leaves the pending bit unchanged.
- R8: A bank's status register reads as pending AND mask. Its interrupt output is high exactly when any status bit is set.
- R9: A slot write and an acknowledge of the same bit in the same cycle leave that pending bit set.
- R10: When both ports write the same slot in one cycle, the high-performance data is stored, and the pending bit is set in both banks.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp_sel | input | 1 | Low-power port access strobe |
| lp_wr | input | 1 | Low-power port write (1) or read (0) |
| lp_addr | input | 6 | Low-power port word address |
| lp_wdata | input | 32 | Low-power port write data |
| lp_rdata | output | 32 | Low-power port read data (combinational) |
| hp_sel | input | 1 | High-performance port access strobe |
| hp_wr | input | 1 | High-performance port write (1) or read (0) |
| hp_addr | input | 6 | High-performance port word address |
| hp_wdata | input | 32 | High-performance port write data |
| hp_rdata | output | 32 | High-performance port read data (combinational) |
| lp_irq | output | 1 | Low-power core interrupt |
| hp_irq | output | 1 | High-performance core interrupt |

## Verification
The assertions assume that an access lasts one cycle with its strobe, address and data stable around the sampling edge. They also assume that read data is only meaningful while a port's select is high and its write strobe is low. The bench drives every access on the falling edge and withdraws it one cycle later. It samples reads and interrupt outputs just after that falling edge, so each access lasts one full cycle and is never observed mid-change. Same-cycle collisions are produced only on purpose, by driving both ports within one falling edge, so that the set-over-acknowledge rule and the port priority can be observed.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned OFS_GATE    = 0;
  localparam int unsigned OFS_LP_PEND = 1;
  localparam int unsigned OFS_LP_MASK = 2;
  localparam int unsigned OFS_LP_STAT = 3;
  localparam int unsigned OFS_LP_ACK  = 4;
  localparam int unsigned OFS_HP_PEND = 5;
  localparam int unsigned OFS_HP_MASK = 6;
  localparam int unsigned OFS_HP_STAT = 7;
  localparam int unsigned OFS_HP_ACK  = 8;

  // Decoded write strobes of one port; bank index 0 = low-power, 1 = high-performance
  typedef struct packed {
    logic       slot_we;
    logic       gate_we;
    logic [1:0] mask_we;
    logic [1:0] ack_we;
  } mbx_wstrb_t;
endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
  import mbx_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 16,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 6,
  localparam int unsigned IDX_W    = ADDR_W - 1
) (
  input  logic                      sel_i,
  input  logic                      wr_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic                      gate_i,
  input  logic [DATA_W-1:0]         slot_rdata_i,
  input  logic [1:0][NUM_SLOTS-1:0] pend_i,
  input  logic [1:0][NUM_SLOTS-1:0] mask_i,
  output mbx_wstrb_t                wstrb_o,
  output logic [IDX_W-1:0]          idx_o,
  output logic [DATA_W-1:0]         rdata_o
);
  localparam logic [IDX_W:0] SLOT_LIM = (IDX_W+1)'(NUM_SLOTS);

  logic             ctl_space;
  logic [IDX_W-1:0] ofs;
  logic             in_range;

  assign ctl_space = addr_i[ADDR_W-1];
  assign ofs       = addr_i[IDX_W-1:0];
  assign in_range  = {1'b0, ofs} < SLOT_LIM;
  assign idx_o     = ofs;

  always_comb begin
    wstrb_o = '0;
    rdata_o = '0;
    if (sel_i) begin
      if (!ctl_space) begin
        if (gate_i && in_range) begin
          wstrb_o.slot_we = wr_i;
          rdata_o         = slot_rdata_i;
        end
      end else begin
        case (ofs)
          IDX_W'(OFS_GATE): begin
            wstrb_o.gate_we = wr_i;
            rdata_o         = DATA_W'(gate_i);
          end
          IDX_W'(OFS_LP_PEND): if (gate_i) rdata_o = DATA_W'(pend_i[0]);
          IDX_W'(OFS_LP_MASK): if (gate_i) begin
            wstrb_o.mask_we[0] = wr_i;
            rdata_o            = DATA_W'(mask_i[0]);
          end
          IDX_W'(OFS_LP_STAT): if (gate_i) rdata_o = DATA_W'(pend_i[0] & mask_i[0]);
          IDX_W'(OFS_LP_ACK):  if (gate_i) wstrb_o.ack_we[0] = wr_i;
          IDX_W'(OFS_HP_PEND): if (gate_i) rdata_o = DATA_W'(pend_i[1]);
          IDX_W'(OFS_HP_MASK): if (gate_i) begin
            wstrb_o.mask_we[1] = wr_i;
            rdata_o            = DATA_W'(mask_i[1]);
          end
          IDX_W'(OFS_HP_STAT): if (gate_i) rdata_o = DATA_W'(pend_i[1] & mask_i[1]);
          IDX_W'(OFS_HP_ACK):  if (gate_i) wstrb_o.ack_we[1] = wr_i;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mbx_slot_store.sv
module mbx_slot_store #(
  parameter int unsigned NUM_SLOTS = 16,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned IDX_W     = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                we_i,
  input  logic [1:0][IDX_W-1:0]     idx_i,
  input  logic [1:0][DATA_W-1:0]    wdata_i,
  output logic [1:0][DATA_W-1:0]    rdata_o,
  output logic [NUM_SLOTS-1:0]      set_o
);
  logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_flat;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic              hit_lp, hit_hp;
    logic [DATA_W-1:0] q, d;

    assign hit_lp = we_i[0] && (idx_i[0] == IDX_W'(s));
    assign hit_hp = we_i[1] && (idx_i[1] == IDX_W'(s));

    always_comb begin
      d = q;
      if (hit_hp)      d = wdata_i[1];
      else if (hit_lp) d = wdata_i[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                q <= '0;
      else if (hit_lp || hit_hp) q <= d;
    end

    assign set_o[s]     = hit_lp | hit_hp;
    assign slot_flat[s] = q;
  end

  always_comb begin
    rdata_o = '0;
    for (int p = 0; p < 2; p++) begin
      for (int s = 0; s < NUM_SLOTS; s++) begin
        if (idx_i[p] == IDX_W'(s)) rdata_o[p] = slot_flat[s];
      end
    end
  end
endmodule

// File: rtl/mbx_irq_bank.sv
module mbx_irq_bank #(
  parameter int unsigned NUM_SLOTS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] set_i,
  input  logic [NUM_SLOTS-1:0] ack_i,
  input  logic                 mask_we_i,
  input  logic [NUM_SLOTS-1:0] mask_wdata_i,
  output logic [NUM_SLOTS-1:0] pend_o,
  output logic [NUM_SLOTS-1:0] mask_o,
  output logic                 irq_o
);
  logic [NUM_SLOTS-1:0] pend_q, pend_d, mask_q, mask_d;
  logic                 pend_en;

  always_comb begin
    pend_en = |(set_i | ack_i);
    pend_d  = (pend_q & ~ack_i) | set_i;
    mask_d  = mask_we_i ? mask_wdata_i : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mask_q <= '0;
    else if (mask_we_i) mask_q <= mask_d;
  end

  assign pend_o = pend_q;
  assign mask_o = mask_q;
  assign irq_o  = |(pend_q & mask_q);
endmodule

// File: rtl/dual_core_mailbox.sv
module dual_core_mailbox
  import mbx_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 16,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lp_sel,
  input  logic              lp_wr,
  input  logic [ADDR_W-1:0] lp_addr,
  input  logic [DATA_W-1:0] lp_wdata,
  output logic [DATA_W-1:0] lp_rdata,
  input  logic              hp_sel,
  input  logic              hp_wr,
  input  logic [ADDR_W-1:0] hp_addr,
  input  logic [DATA_W-1:0] hp_wdata,
  output logic [DATA_W-1:0] hp_rdata,
  output logic              lp_irq,
  output logic              hp_irq
);
  localparam int unsigned IDX_W = ADDR_W - 1;

  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic [1:0]                     sel_v, wr_v;
  logic [1:0][ADDR_W-1:0]         addr_v;
  logic [1:0][DATA_W-1:0]         wdata_v, rdata_v, slot_rd_v;
  logic [1:0][IDX_W-1:0]          idx_v;
  mbx_wstrb_t [1:0]               wstrb_v;
  logic [1:0]                     slot_we_v;
  logic [NUM_SLOTS-1:0]           set_vec;
  logic [1:0][NUM_SLOTS-1:0]      ack_vec, pend_vec, mask_vec, mask_wd_vec;
  logic [1:0]                     mask_we_vec, irq_vec;
  logic                           gate_q, gate_d, gate_en;

  assign sel_v   = {hp_sel, lp_sel};
  assign wr_v    = {hp_wr, lp_wr};
  assign addr_v  = {hp_addr, lp_addr};
  assign wdata_v = {hp_wdata, lp_wdata};

  for (genvar p = 0; p < 2; p++) begin : g_port
    mbx_port_decode #(
      .NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) dec_i (
      .sel_i        (sel_v[p]),
      .wr_i         (wr_v[p]),
      .addr_i       (addr_v[p]),
      .gate_i       (gate_q),
      .slot_rdata_i (slot_rd_v[p]),
      .pend_i       (pend_vec),
      .mask_i       (mask_vec),
      .wstrb_o      (wstrb_v[p]),
      .idx_o        (idx_v[p]),
      .rdata_o      (rdata_v[p])
    );
    assign slot_we_v[p] = wstrb_v[p].slot_we;
  end

  // Gate bit: high-performance port wins a same-cycle write
  always_comb begin
    gate_en = wstrb_v[0].gate_we | wstrb_v[1].gate_we;
    gate_d  = wstrb_v[1].gate_we ? hp_wdata[0] : lp_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  gate_q <= 1'b0;
    else if (gate_en) gate_q <= gate_d;
  end

  mbx_slot_store #(
    .NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) store_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .we_i    (slot_we_v),
    .idx_i   (idx_v),
    .wdata_i (wdata_v),
    .rdata_o (slot_rd_v),
    .set_o   (set_vec)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    always_comb begin
      ack_vec[b]     = (wstrb_v[0].ack_we[b] ? lp_wdata[NUM_SLOTS-1:0] : '0)
                     | (wstrb_v[1].ack_we[b] ? hp_wdata[NUM_SLOTS-1:0] : '0);
      mask_we_vec[b] = wstrb_v[0].mask_we[b] | wstrb_v[1].mask_we[b];
      mask_wd_vec[b] = wstrb_v[1].mask_we[b] ? hp_wdata[NUM_SLOTS-1:0]
                                             : lp_wdata[NUM_SLOTS-1:0];
    end

    mbx_irq_bank #(.NUM_SLOTS(NUM_SLOTS)) bank_i (
      .clk          (clk),
      .rst_n        (rst_sync_n),
      .set_i        (set_vec),
      .ack_i        (ack_vec[b]),
      .mask_we_i    (mask_we_vec[b]),
      .mask_wdata_i (mask_wd_vec[b]),
      .pend_o       (pend_vec[b]),
      .mask_o       (mask_vec[b]),
      .irq_o        (irq_vec[b])
    );
  end

  assign lp_rdata = rdata_v[0];
  assign hp_rdata = rdata_v[1];
  assign lp_irq   = irq_vec[0];
  assign hp_irq   = irq_vec[1];
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
  parameter int unsigned NUM_SLOTS = 16,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 6
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      gate,
  input logic [NUM_SLOTS-1:0]      set_vec,
  input logic [1:0][NUM_SLOTS-1:0] ack_vec,
  input logic [1:0][NUM_SLOTS-1:0] pend_vec,
  input logic [1:0][NUM_SLOTS-1:0] mask_vec,
  input logic                      lp_irq,
  input logic                      hp_irq,
  input logic                      lp_sel,
  input logic                      lp_wr,
  input logic [ADDR_W-1:0]         lp_addr,
  input logic [DATA_W-1:0]         lp_rdata
);
  localparam logic [ADDR_W-2:0] SLOT_LIM = (ADDR_W-1)'(NUM_SLOTS);

  assert_write_sets_both_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((pend_vec[0] & $past(set_vec)) == $past(set_vec)) &&
                        ((pend_vec[1] & $past(set_vec)) == $past(set_vec)));

  assert_set_beats_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_vec & (ack_vec[0] | ack_vec[1])) != '0) |=>
      ((pend_vec[0] & $past(set_vec & ack_vec[0])) == $past(set_vec & ack_vec[0])) &&
      ((pend_vec[1] & $past(set_vec & ack_vec[1])) == $past(set_vec & ack_vec[1])));

  assert_ack_clears_lp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack_vec[0] & ~set_vec) != '0) |=> ((pend_vec[0] & $past(ack_vec[0] & ~set_vec)) == '0));

  assert_ack_clears_hp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack_vec[1] & ~set_vec) != '0) |=> ((pend_vec[1] & $past(ack_vec[1] & ~set_vec)) == '0));

  assert_gate_holds_banks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !gate |=> $stable(pend_vec) && $stable(mask_vec));

  assert_lp_irq_needs_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_vec[0] == '0) |-> !lp_irq);

  assert_hp_irq_needs_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_vec[1] == '0) |-> !hp_irq);

  assert_oob_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_sel && !lp_wr && !lp_addr[ADDR_W-1] && (lp_addr[ADDR_W-2:0] >= SLOT_LIM))
      |-> (lp_rdata == '0));
endmodule

bind dual_core_mailbox mbx_checker #(
  .NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .gate     (gate_q),
  .set_vec  (set_vec),
  .ack_vec  (ack_vec),
  .pend_vec (pend_vec),
  .mask_vec (mask_vec),
  .lp_irq   (lp_irq),
  .hp_irq   (hp_irq),
  .lp_sel   (lp_sel),
  .lp_wr    (lp_wr),
  .lp_addr  (lp_addr),
  .lp_rdata (lp_rdata)
);

// File: tb/dual_core_mailbox_tb_top.sv
`timescale 1ns/1ps
module dual_core_mailbox_tb_top;
  localparam logic [5:0] A_GATE = 6'h20, A_LP_PEND = 6'h21, A_LP_MASK = 6'h22,
                         A_LP_STAT = 6'h23, A_LP_ACK = 6'h24, A_HP_PEND = 6'h25,
                         A_HP_MASK = 6'h26, A_HP_STAT = 6'h27, A_HP_ACK = 6'h28;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lp_sel, lp_wr, hp_sel, hp_wr;
  logic [5:0]  lp_addr, hp_addr;
  logic [31:0] lp_wdata, hp_wdata, lp_rdata, hp_rdata;
  logic        lp_irq, hp_irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [31:0] mem_m [16];
  logic [15:0] lp_pend_m, hp_pend_m;

  always #2.5 clk = ~clk;

  dual_core_mailbox dut_i (
    .clk(clk), .rst_n(rst_n),
    .lp_sel(lp_sel), .lp_wr(lp_wr), .lp_addr(lp_addr), .lp_wdata(lp_wdata), .lp_rdata(lp_rdata),
    .hp_sel(hp_sel), .hp_wr(hp_wr), .hp_addr(hp_addr), .hp_wdata(hp_wdata), .hp_rdata(hp_rdata),
    .lp_irq(lp_irq), .hp_irq(hp_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_all();
    lp_sel = 0; lp_wr = 0; lp_addr = '0; lp_wdata = '0;
    hp_sel = 0; hp_wr = 0; hp_addr = '0; hp_wdata = '0;
  endtask

  task automatic drive(input int p, input logic wr, input logic [5:0] a, input logic [31:0] d);
    if (p == 0) begin lp_sel = 1; lp_wr = wr; lp_addr = a; lp_wdata = d; end
    else        begin hp_sel = 1; hp_wr = wr; hp_addr = a; hp_wdata = d; end
  endtask

  task automatic wr1(input int p, input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); idle_all(); drive(p, 1, a, d);
    @(negedge clk); idle_all();
  endtask

  task automatic wr2(input logic [5:0] la, input logic [31:0] ld,
                     input logic [5:0] ha, input logic [31:0] hd);
    @(negedge clk); idle_all(); drive(0, 1, la, ld); drive(1, 1, ha, hd);
    @(negedge clk); idle_all();
  endtask

  task automatic rd(input int p, input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); idle_all(); drive(p, 0, a, '0);
    #1 d = (p == 0) ? lp_rdata : hp_rdata;
    idle_all();
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; idle_all();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 0; idle_all();
    do_reset();

    // R1 reset state
    check("R1 lp_irq", {31'd0, lp_irq}, 0);
    check("R1 hp_irq", {31'd0, hp_irq}, 0);
    rd(0, A_GATE, v); check("R1 gate", v, 0);

    // R2 gated accesses ignored
    wr1(0, 6'd2, 32'h12345678);
    wr1(1, A_LP_MASK, 32'hFFFF);
    rd(1, A_LP_PEND, v); check("R2 gated read", v, 0);
    wr1(1, A_GATE, 32'h1);
    rd(0, A_GATE, v); check("R2 gate set", v, 1);
    rd(0, 6'd2, v); check("R2 slot untouched", v, 0);
    rd(0, A_LP_PEND, v); check("R2 no pend", v, 0);
    rd(1, A_LP_MASK, v); check("R2 mask untouched", v, 0);
    check("R1 slots zero: irq", {31'd0, lp_irq | hp_irq}, 0);

    // R3/R5 sweep over all slots, alternating writer
    lp_pend_m = '0; hp_pend_m = '0;
    for (int i = 0; i < 16; i++) begin
      mem_m[i] = 32'hA5000000 ^ (i * 32'h01010101) ^ (32'h1 << (i + 8));
      wr1(i % 2, 6'(i), mem_m[i]);
      lp_pend_m[i] = 1'b1; hp_pend_m[i] = 1'b1;
      rd(1 - (i % 2), 6'(i), v); check("R3 slot readback", v, mem_m[i]);
      rd(0, A_LP_PEND, v); check("R5 lp pend", v, {16'd0, lp_pend_m});
      rd(1, A_HP_PEND, v); check("R5 hp pend", v, {16'd0, hp_pend_m});
    end

    // R6 acknowledge per bank
    wr1(0, A_LP_ACK, 32'h00FF); lp_pend_m &= ~16'h00FF;
    rd(0, A_LP_PEND, v); check("R6 lp ack", v, {16'd0, lp_pend_m});
    rd(0, A_HP_PEND, v); check("R6 hp untouched", v, {16'd0, hp_pend_m});
    rd(1, A_LP_ACK, v);  check("R6 ack reads zero", v, 0);
    wr1(1, A_HP_ACK, 32'hFFFF); hp_pend_m = '0;
    rd(1, A_HP_PEND, v); check("R6 hp ack", v, 0);
    rd(1, A_LP_PEND, v); check("R6 lp untouched", v, {16'd0, lp_pend_m});

    // R4 out-of-range slot indices
    for (int a = 16; a < 32; a++) begin
      wr1(a % 2, 6'(a), 32'hDEAD0000 | a);
      rd(1 - (a % 2), 6'(a), v); check("R4 oob read", v, 0);
    end
    rd(0, A_LP_PEND, v); check("R4 no lp pend", v, {16'd0, lp_pend_m});
    rd(0, A_HP_PEND, v); check("R4 no hp pend", v, 0);
    for (int i = 0; i < 16; i++) begin
      rd(i % 2, 6'(i), v); check("R4 slots intact", v, mem_m[i]);
    end

    // R7/R8 masks, status and interrupt outputs
    wr1(1, A_HP_MASK, 32'h0F0F);
    rd(0, A_HP_MASK, v); check("R7 mask readback", v, 32'h0F0F);
    rd(1, A_HP_STAT, v); check("R8 hp stat", v, 0);
    check("R8 hp_irq low", {31'd0, hp_irq}, 0);
    wr1(0, A_LP_MASK, 32'h0300);
    rd(0, A_LP_STAT, v); check("R8 lp stat", v, {16'd0, lp_pend_m & 16'h0300});
    check("R8 lp_irq high", {31'd0, lp_irq}, 1);
    mem_m[1] = 32'hCAFEF00D;
    wr1(0, 6'd1, mem_m[1]); lp_pend_m[1] = 1; hp_pend_m[1] = 1;
    rd(1, A_HP_STAT, v); check("R8 hp stat set", v, 32'h0002);
    check("R8 hp_irq high", {31'd0, hp_irq}, 1);
    wr1(0, A_LP_MASK, 32'h0);
    check("R8 lp_irq off", {31'd0, lp_irq}, 0);
    rd(0, A_LP_PEND, v); check("R7 pend kept", v, {16'd0, lp_pend_m});
    for (int k = 0; k < 16; k++) begin
      wr1(k % 2, A_HP_MASK, 32'h1 << k);
      check("R8 hp_irq per bit", {31'd0, hp_irq}, {31'd0, hp_pend_m[k]});
    end

    // R9 slot write and acknowledge of the same bit in one cycle
    mem_m[3] = 32'h33333333;
    wr2(6'd3, mem_m[3], A_LP_ACK, 32'h000A);
    lp_pend_m[1] = 0; lp_pend_m[3] = 1; hp_pend_m[3] = 1;
    rd(0, A_LP_PEND, v); check("R9 set wins", v, {16'd0, lp_pend_m});
    rd(1, A_HP_PEND, v); check("R9 hp set", v, {16'd0, hp_pend_m});

    // R10 both ports write slot 5
    wr2(6'd5, 32'h11111111, 6'd5, 32'h22222222);
    mem_m[5] = 32'h22222222; lp_pend_m[5] = 1; hp_pend_m[5] = 1;
    rd(0, 6'd5, v); check("R10 hp data wins", v, mem_m[5]);
    rd(0, A_LP_PEND, v); check("R10 lp pend", v, {16'd0, lp_pend_m});
    rd(1, A_HP_PEND, v); check("R10 hp pend", v, {16'd0, hp_pend_m});

    // R2 gate cleared again
    wr1(0, A_GATE, 32'h0);
    rd(0, 6'd5, v); check("R2 gated slot read", v, 0);
    rd(1, A_LP_PEND, v); check("R2 gated pend read", v, 0);
    wr1(1, 6'd5, 32'h55555555);
    wr1(0, A_GATE, 32'h1);
    rd(1, 6'd5, v); check("R2 gated write ignored", v, mem_m[5]);

    // R1 reset mid-run
    do_reset();
    check("R1 irq after reset", {30'd0, lp_irq, hp_irq}, 0);
    rd(1, A_GATE, v); check("R1 gate after reset", v, 0);
    wr1(0, A_GATE, 32'h1);
    rd(0, 6'd5, v); check("R1 slot cleared", v, 0);
    rd(0, A_HP_PEND, v); check("R1 pend cleared", v, 0);
    rd(1, A_HP_MASK, v); check("R1 mask cleared", v, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule